// File: doc/BRIEF.md
# Serial Receive FIFO with Fill-Level Auto-Stop

This block sits between the bit-level shifter of a serial receiver and the CPU. Every byte the shifter completes is first caught in a one-byte holding buffer and then moved into a four-stage first-in first-out store, along with a flag recording whether that byte arrived with a parity error. The CPU reads the oldest byte from the head of the store with a single-cycle read strobe.

A two-bit fill-level field sets both the number of stages in use and the point at which a receive interrupt pulse fires. A clear command empties the store and latches the interrupt condition: pulse once when the count first reaches the level, or pulse on every transfer that leaves the count at or above it. In half-duplex clocked mode, with auto-stop selected, the block drops its own receive enable when the level is reached. This halts the serial clock, so a fixed-length burst is received with no CPU action.

Two small state machines control the block. The enable machine has the states EN_OFF, EN_RUN and EN_HALT. A software write of 1 takes EN_OFF or EN_HALT to EN_RUN. A software write of 0 takes EN_RUN or EN_HALT to EN_OFF. Reaching the fill level with auto-stop active in half-duplex mode takes EN_RUN to EN_HALT. The holding buffer machine has the states BUF_EMPTY and BUF_HELD. An accepted byte takes BUF_EMPTY to BUF_HELD. A transfer into the store with no new byte in the same cycle takes BUF_HELD back to BUF_EMPTY.

Top module: `rx_fifo_autostop`

## Requirements
- R1: A byte strobed while `rx_en`=1 sets `buf_full` on the next cycle. If the store has room, the byte enters the store one cycle later, and in that same cycle `fifo_cnt` increments and `buf_full` drops.
- R2: While `rx_en`=0, `byte_done` is ignored: `buf_full` and `fifo_cnt` do not change.
- R3: Bytes leave the store oldest first. `rd_data` and `rd_perr` show the head entry. `rd_stb` removes the head. `rd_stb` on an empty store has no effect. `fifo_cnt` never exceeds 4.
- R4: Stages in use equal the level: `fill_sel` 2'b00 gives 4, 2'b01 gives 1, 2'b10 gives 2, 2'b11 gives 3. A byte arriving when the store is at that level waits in the buffer with `buf_full`=1.
- R5: A byte arriving while the buffer is held and no transfer can occur in that cycle sets `overrun` and is discarded.
- R6: In condition 0, `rx_irq` is a one-cycle pulse in the cycle `fifo_cnt` first equals the level. In condition 1, `rx_irq` pulses in the cycle after every transfer that leaves the count at or above the level.
- R7: With `half_duplex`=1 and `auto_stop`=1, `rx_en` falls in the same cycle the count reaches the level. After that, further bytes are ignored until `rx_en` is rewritten. `sclk_run` equals `rx_en` AND `half_duplex`.
- R8: A read and a buffer-to-store transfer in the same cycle are both carried out, and `fifo_cnt` is unchanged.
- R9: `clr_wr` with `clr_code`=2'b11 empties the store, clears `overrun` and latches `irq_cond` as the interrupt condition. Any other code has no effect. In that cycle the clear wins over a transfer, and a held byte moves in on the next cycle.
- R10: The parity-error bit of each byte is stored with it and appears on `rd_perr` when that byte is at the head.
- R11: After reset, `rx_en`, `fifo_cnt`, `buf_full`, `rx_irq`, `overrun` and `sclk_run` are all 0, and the interrupt condition is 0.
- R12: `en_wr` with `en_wdata`=1 sets `rx_en`. `en_wr` with `en_wdata`=0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_done | input | 1 | Shifter finished a byte |
| byte_data | input | 8 | Byte from the shifter |
| byte_perr | input | 1 | Parity error on that byte |
| en_wr | input | 1 | Write strobe for receive enable |
| en_wdata | input | 1 | Value written to receive enable |
| half_duplex | input | 1 | Half-duplex clocked mode selected |
| auto_stop | input | 1 | Stop receiving on reaching the level |
| fill_sel | input | 2 | Fill level and stages in use |
| irq_cond | input | 1 | Interrupt condition latched on clear |
| clr_wr | input | 1 | Write strobe for clear control |
| clr_code | input | 2 | Clear control; 2'b11 clears |
| rd_stb | input | 1 | CPU read of the head byte |
| rd_data | output | 8 | Head byte |
| rd_perr | output | 1 | Parity error of head byte |
| fifo_cnt | output | 3 | Bytes in the store |
| rx_irq | output | 1 | Receive interrupt pulse |
| buf_full | output | 1 | Holding buffer occupied |
| overrun | output | 1 | A byte was lost |
| rx_en | output | 1 | Receive enable |
| sclk_run | output | 1 | Serial clock may run |

## Verification
The hardest state to reach from the ports is the holding buffer occupied while the store sits at its level, with a read, a clear or a new byte landing in that exact cycle. Only that combination exercises overrun, read-plus-transfer and clear priority. The stimulus reaches it by lowering the level to one or two stages, so the store fills after very few bytes. It then strobes a byte while the store is full and sets the next operation in the following cycle. Auto-stop is reached the same way, with a small level, and the bench then confirms that a byte strobed after the stop never shows up.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        EN_OFF  = 2'd0,
        EN_RUN  = 2'd1,
        EN_HALT = 2'd2
    } en_state_t;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_HELD  = 1'b1
    } buf_state_t;

    typedef enum logic {
        IRQ_ON_REACH = 1'b0,
        IRQ_ON_EVERY = 1'b1
    } irq_mode_t;
endpackage

// File: rtl/rxf_hold_buf.sv
module rxf_hold_buf
    import rxf_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         take,
    input  logic         ovr_clr,
    input  logic [W-1:0] din,
    output logic         held,
    output logic [W-1:0] dout,
    output logic         ovr
);
    buf_state_t state_q, state_d;
    logic [W-1:0] data_q;
    logic         ovr_q;
    logic         accept;
    logic         ovr_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (load)          state_d = BUF_HELD;
            BUF_HELD:  if (take && !load) state_d = BUF_EMPTY;
            default:                      state_d = BUF_EMPTY;
        endcase
    end

    // a slot is free if empty or emptying this cycle
    assign accept  = load && ((state_q == BUF_EMPTY) || take);
    assign ovr_set = load && (state_q == BUF_HELD) && !take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (accept)       data_q <= din;
            if (ovr_clr)      ovr_q  <= 1'b0;
            else if (ovr_set) ovr_q  <= 1'b1;
        end
    end

    always_comb begin
        held = (state_q == BUF_HELD);
        dout = data_q;
        ovr  = ovr_q;
    end
endmodule

// File: rtl/rxf_ring.sv
module rxf_ring #(
    parameter int W     = 9,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] cnt
);
    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] we;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign we[g] = push && (wr_ptr == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we[i]) mem[i] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head = mem[rd_ptr];
    assign cnt  = cnt_q;
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_wdata,
    input  logic             stop_ok,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic             cond_in,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] level,
    output logic             rx_en,
    output logic             irq
);
    en_state_t        st_q, st_d;
    irq_mode_t        mode_q;
    logic             irq_q;
    logic [CNT_W-1:0] cnt_next;
    logic             reach;
    logic             every;

    always_comb begin
        if (flush)            cnt_next = '0;
        else if (push && !pop) cnt_next = cnt + CNT_W'(1);
        else if (pop && !push) cnt_next = cnt - CNT_W'(1);
        else                  cnt_next = cnt;
    end

    assign reach = push && !pop && !flush && (cnt_next == level);
    assign every = push && !flush && (cnt_next >= level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EN_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_OFF:  if (en_wr && en_wdata) st_d = EN_RUN;
            EN_RUN:  begin
                if (en_wr)                 st_d = en_wdata ? EN_RUN : EN_OFF;
                else if (reach && stop_ok) st_d = EN_HALT;
            end
            EN_HALT: if (en_wr)             st_d = en_wdata ? EN_RUN : EN_OFF;
            default:                        st_d = EN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= IRQ_ON_REACH;
            irq_q  <= 1'b0;
        end else begin
            if (flush) mode_q <= irq_mode_t'(cond_in);
            irq_q <= (mode_q == IRQ_ON_EVERY) ? every : reach;
        end
    end

    always_comb begin
        rx_en = (st_q == EN_RUN);
        irq   = irq_q;
    end
endmodule

// File: rtl/rx_fifo_autostop.sv
module rx_fifo_autostop
    import rxf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int LVL_W  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int ENT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_perr,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              half_duplex,
    input  logic              auto_stop,
    input  logic [LVL_W-1:0]  fill_sel,
    input  logic              irq_cond,
    input  logic              clr_wr,
    input  logic [1:0]        clr_code,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_perr,
    output logic [CNT_W-1:0]  fifo_cnt,
    output logic              rx_irq,
    output logic              buf_full,
    output logic              overrun,
    output logic              rx_en,
    output logic              sclk_run
);
    logic             load, flush, full, pop, xfer;
    logic [CNT_W-1:0] level;
    logic [ENT_W-1:0] buf_q, head;

    assign level = (fill_sel == '0) ? CNT_W'(DEPTH) : CNT_W'(fill_sel);
    assign load  = byte_done && rx_en;
    assign flush = clr_wr && (clr_code == 2'b11);
    assign full  = (fifo_cnt >= level);
    assign pop   = rd_stb && (fifo_cnt != '0) && !flush;
    assign xfer  = buf_full && !flush && (!full || pop);

    rxf_hold_buf #(.W(ENT_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .take    (xfer),
        .ovr_clr (flush),
        .din     ({byte_perr, byte_data}),
        .held    (buf_full),
        .dout    (buf_q),
        .ovr     (overrun)
    );

    rxf_ring #(.W(ENT_W), .DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (xfer),
        .pop   (pop),
        .flush (flush),
        .din   (buf_q),
        .head  (head),
        .cnt   (fifo_cnt)
    );

    rxf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .stop_ok  (auto_stop && half_duplex),
        .push     (xfer),
        .pop      (pop),
        .flush    (flush),
        .cond_in  (irq_cond),
        .cnt      (fifo_cnt),
        .level    (level),
        .rx_en    (rx_en),
        .irq      (rx_irq)
    );

    assign rd_data  = head[DATA_W-1:0];
    assign rd_perr  = head[DATA_W];
    assign sclk_run = rx_en && half_duplex;
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_done,
    input logic             en_wr,
    input logic             clr_wr,
    input logic [1:0]       clr_code,
    input logic             rd_stb,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             rx_irq,
    input logic             buf_full,
    input logic             overrun,
    input logic             rx_en,
    input logic             sclk_run
);
    logic clr_fire;
    assign clr_fire = clr_wr && (clr_code == 2'b11);

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    p_buf_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && fifo_cnt == '0 && !clr_fire) |=> (fifo_cnt == CNT_W'(1)));

    p_autostop_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rx_en) && !$past(en_wr)) |-> rx_irq);

    p_sclk_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_run |-> rx_en);

    p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(byte_done && rx_en && buf_full));

    p_rd_xfer_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && fifo_cnt != '0 && buf_full && !clr_fire) |=> $stable(fifo_cnt));

    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |=> (fifo_cnt == '0 && !overrun));
endmodule

bind rx_fifo_autostop rxf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_done (byte_done),
    .en_wr     (en_wr),
    .clr_wr    (clr_wr),
    .clr_code  (clr_code),
    .rd_stb    (rd_stb),
    .fifo_cnt  (fifo_cnt),
    .rx_irq    (rx_irq),
    .buf_full  (buf_full),
    .overrun   (overrun),
    .rx_en     (rx_en),
    .sclk_run  (sclk_run)
);

// File: tb/sim_rx_fifo_autostop.sv
`timescale 1ns/1ps
module sim_rx_fifo_autostop;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_done = 0, byte_perr = 0, en_wr = 0, en_wdata = 0;
    logic       half_duplex = 0, auto_stop = 0, irq_cond = 0, clr_wr = 0, rd_stb = 0;
    logic [7:0] byte_data = 0;
    logic [1:0] fill_sel = 0, clr_code = 0;
    logic [7:0] rd_data;
    logic       rd_perr, rx_irq, buf_full, overrun, rx_en, sclk_run;
    logic [2:0] fifo_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rx_fifo_autostop u0 (.*);

    // {op[1:0] (bit0 byte, bit1 read), data, perr, exp_cnt, exp_buf, exp_irq, exp_head, exp_hperr}
    localparam logic [24:0] VEC [14] = '{
        {2'd1, 8'hA1, 1'b0, 3'd0, 1'b1, 1'b0, 8'h00, 1'b0},
        {2'd0, 8'h00, 1'b0, 3'd1, 1'b0, 1'b0, 8'hA1, 1'b0},
        {2'd1, 8'hB2, 1'b1, 3'd1, 1'b1, 1'b0, 8'hA1, 1'b0},
        {2'd1, 8'hC3, 1'b0, 3'd2, 1'b1, 1'b0, 8'hA1, 1'b0},
        {2'd1, 8'hD4, 1'b0, 3'd3, 1'b1, 1'b0, 8'hA1, 1'b0},
        {2'd0, 8'h00, 1'b0, 3'd4, 1'b0, 1'b1, 8'hA1, 1'b0},
        {2'd0, 8'h00, 1'b0, 3'd4, 1'b0, 1'b0, 8'hA1, 1'b0},
        {2'd1, 8'hE5, 1'b1, 3'd4, 1'b1, 1'b0, 8'hA1, 1'b0},
        {2'd2, 8'h00, 1'b0, 3'd4, 1'b0, 1'b0, 8'hB2, 1'b1},
        {2'd2, 8'h00, 1'b0, 3'd3, 1'b0, 1'b0, 8'hC3, 1'b0},
        {2'd2, 8'h00, 1'b0, 3'd2, 1'b0, 1'b0, 8'hD4, 1'b0},
        {2'd2, 8'h00, 1'b0, 3'd1, 1'b0, 1'b0, 8'hE5, 1'b1},
        {2'd2, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0},
        {2'd2, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        byte_done = 0; rd_stb = 0; en_wr = 0; clr_wr = 0;
    endtask

    task automatic send(input logic [7:0] d, input logic p);
        byte_done = 1; byte_data = d; byte_perr = p;
    endtask

    task automatic do_clear(input logic cond);
        clr_wr = 1; clr_code = 2'b11; irq_cond = cond;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        chk("R11 rx_en", rx_en, 0);
        chk("R11 fifo_cnt", fifo_cnt, 0);
        chk("R11 buf_full", buf_full, 0);
        chk("R11 rx_irq", rx_irq, 0);
        chk("R11 overrun", overrun, 0);
        chk("R11 sclk_run", sclk_run, 0);

        en_wr = 1; en_wdata = 1; tick();
        chk("R12 enable set", rx_en, 1);

        // table: level 4, condition 0 (R1 R3 R4 R6 R8 R10)
        for (int i = 0; i < 14; i++) begin
            logic [24:0] v;
            v = VEC[i];
            if (v[24]) begin rd_stb = 1; end
            if (v[23]) send(v[22:15], v[14]);
            tick();
            chk($sformatf("R1/R3 cnt step %0d", i), fifo_cnt, v[13:11]);
            chk($sformatf("R1/R4 buf step %0d", i), buf_full, v[10]);
            chk($sformatf("R6 irq step %0d", i), rx_irq, v[9]);
            if (v[13:11] != 0) begin
                chk($sformatf("R3 head step %0d", i), rd_data, v[8:1]);
                chk($sformatf("R10 perr step %0d", i), rd_perr, v[0]);
            end
        end

        // R2 / R12: disabled receiver ignores bytes
        en_wr = 1; en_wdata = 0; tick();
        chk("R12 enable clear", rx_en, 0);
        send(8'h77, 0); tick();
        chk("R2 buf ignored", buf_full, 0);
        tick();
        chk("R2 cnt ignored", fifo_cnt, 0);
        en_wr = 1; en_wdata = 1; tick();

        // R4 / R5: level 1
        fill_sel = 2'b01;
        send(8'h11, 0); tick(); tick();
        chk("R4 level1 cnt", fifo_cnt, 1);
        chk("R6 level1 irq", rx_irq, 1);
        send(8'h22, 0); tick();
        chk("R4 held when full", buf_full, 1);
        chk("R4 cnt held", fifo_cnt, 1);
        send(8'h33, 0); tick();
        chk("R5 overrun set", overrun, 1);
        rd_stb = 1; tick();
        chk("R5 cnt after read", fifo_cnt, 1);
        chk("R5 head is kept byte", rd_data, 8'h22);
        rd_stb = 1; tick(); tick();
        chk("R5 dropped byte absent", fifo_cnt, 0);
        chk("R5 buffer empty", buf_full, 0);

        // R9: other code is ignored, 11 clears and latches condition 1
        clr_wr = 1; clr_code = 2'b10; irq_cond = 1; tick();
        chk("R9 code 10 no effect", overrun, 1);
        do_clear(1);
        chk("R9 overrun cleared", overrun, 0);
        chk("R9 cnt cleared", fifo_cnt, 0);

        // R6 condition 1, level 2
        fill_sel = 2'b10;
        send(8'h44, 0); tick(); tick();
        chk("R6 every below level", rx_irq, 0);
        send(8'h55, 0); tick(); tick();
        chk("R6 every at level", rx_irq, 1);
        send(8'h66, 0); tick();
        rd_stb = 1; tick();
        chk("R8 cnt unchanged", fifo_cnt, 2);
        chk("R6 every on read+move", rx_irq, 1);
        chk("R3 head after read", rd_data, 8'h55);

        // R9 clear priority over a pending transfer
        rd_stb = 1; tick();
        rd_stb = 1; tick();
        send(8'h77, 0); tick(); tick();
        send(8'h78, 1); tick();
        chk("R9 setup held", buf_full, 1);
        do_clear(0);
        chk("R9 clear wins cnt", fifo_cnt, 0);
        chk("R9 clear wins buf", buf_full, 1);
        tick();
        chk("R9 byte moves next", fifo_cnt, 1);
        chk("R9 moved byte", rd_data, 8'h78);
        chk("R10 moved perr", rd_perr, 1);

        // R7 auto-stop in half-duplex
        do_clear(0);
        half_duplex = 1; auto_stop = 1;
        #1;
        chk("R7 sclk runs", sclk_run, 1);
        send(8'h81, 0); tick(); tick();
        send(8'h82, 0); tick();
        chk("R7 still running", rx_en, 1);
        tick();
        chk("R7 enable dropped", rx_en, 0);
        chk("R7 sclk stopped", sclk_run, 0);
        chk("R7 irq at stop", rx_irq, 1);
        send(8'h83, 0); tick(); tick();
        chk("R7 later byte ignored", fifo_cnt, 2);
        chk("R7 buf stays empty", buf_full, 0);

        // R7 no stop outside half-duplex
        do_clear(0);
        half_duplex = 0;
        en_wr = 1; en_wdata = 1; tick();
        chk("R7 no sclk full duplex", sclk_run, 0);
        send(8'h91, 0); tick(); tick();
        send(8'h92, 0); tick(); tick();
        chk("R7 no stop full duplex", rx_en, 1);
        chk("R7 cnt full duplex", fifo_cnt, 2);

        finish_run();
    end
endmodule